// File: doc/BRIEF.md
# I2C Register Target with High-Speed Mode Tracking

This block is a synchronous I2C target that an external bus master uses to read and write a small bank of byte-wide registers. It runs entirely on the system clock. SCL and SDA are oversampled through a short synchronizer, and bus conditions and clock edges are found from the synchronized copies. The block never drives SDA high. Its only SDA output is a pull-down enable, which the pad turns into an open-drain low.

A write moves one data byte into the register that an address byte selects. A read first loads the register pointer with a write-direction header. A repeated START and a read-direction header follow, and the target then streams bytes from the pointer. Each byte the master acknowledges advances the pointer by one. The block also recognises the high-speed master code. It raises a mode flag at the next repeated START and holds that flag until a STOP.

Top module: `i2c_hs_target`

## Requirements
- R1: A START or repeated START (SDA falls while SCL is high) restarts byte framing at the device-address byte, even in the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle.
- R2: Address and data bits are captured on the rising SCL edge, and read data is shifted out most-significant bit first.
- R3: The SDA pull-down enable switches on only while SCL is low, and it is off after every STOP.
- R4: With the device address (default 7'h52, header byte 0xA4), the sequence START, header, register-address byte, data byte is acknowledged on all three bytes, and the data byte is stored.
- R5: The register index is the low log2(NUM_REGS) bits of the register-address byte, so the upper bits are ignored. Register i resets to RST_BASE | i (default 0xC0 | i).
- R6: A read header (0xA5) is acknowledged. The target then drives the byte at the pointer and releases SDA for the master's acknowledge bit.
- R7: A master ACK (SDA 0) after a read byte advances the pointer, wrapping modulo NUM_REGS, and the next byte is sent. A master NACK (SDA 1) leaves the pointer unchanged, and a later read without a pointer write starts from it.
- R8: A header whose upper seven bits differ from the device address gets no ACK. The block then ignores the bus and stores nothing until the next START or STOP.
- R9: A second data byte in a write gets no ACK and is not stored.
- R10: A byte whose top five bits are 00001, received as the first byte after a START on an idle bus, is not acknowledged and does not by itself set the mode flag.
- R11: The START that follows a master code sets hs_mode_o. The flag stays set across later repeated STARTs and clears only on STOP. Transfers work normally while it is set.
- R12: After reset, the pull-down enable and hs_mode_o are 0 and the register pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the fastest SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| hs_mode_o | output | 1 | High-speed mode flag |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it deliberately makes a START or STOP. They also assume that SCL phases span several system clocks, so the synchronizer never merges two edges. The bench master keeps every SDA change a quarter bit-period away from each SCL edge. It uses at least three system clocks per quarter, including the faster high-speed phase, and it never makes a START or STOP while the target could be pulling SDA low.

// File: rtl/i2c_hs_pkg.sv
// Package: shared types for the I2C register target.
// Assumes: byte-wide bus transfers; state encodings are internal only.
package i2c_hs_pkg;

    // Protocol engine states
    typedef enum logic [3:0] {
        ST_IDLE,       // ignore bus until START/STOP
        ST_DEV,        // shifting the device header
        ST_REG,        // shifting the register address
        ST_WDATA,      // shifting write data
        ST_ACK_WAIT,   // byte taken, wait for SCL low to pull ACK
        ST_ACK_HOLD,   // ACK driven, wait for end of ACK clock
        ST_RDATA,      // driving read data bits
        ST_RACK_WAIT,  // last read bit out, wait for SCL low to release
        ST_RACK,       // sample master ACK/NACK
        ST_RLOAD       // load next read byte on SCL fall
    } tgt_state_e;

    // What follows an acknowledge slot
    typedef enum logic [1:0] {
        NX_REG,
        NX_WDATA,
        NX_RDATA,
        NX_DONE
    } ack_next_e;

    localparam int          BYTE_W        = 8;
    localparam logic [4:0]  MCODE_PREFIX  = 5'b00001;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Synchronizes SCL and SDA into the system clock domain and derives SCL
// edges plus START and STOP conditions from the synchronized values.
// Assumes: the bus idles high; system clock is >= 8x the SCL rate.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    // Purpose: multi-flop synchronizer chains, reset to the idle-high level
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Purpose: one-cycle history for edge and condition detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Purpose: decode edges and bus conditions
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_reg_bank.sv
// Module: i2c_reg_bank
// Bank of byte registers with one write port and one combinational read
// port. Register i resets to RST_BASE | i.
// Assumes: NUM_REGS is a power of two and IDX_W = log2(NUM_REGS).
module i2c_reg_bank #(
    parameter int         NUM_REGS = 16,
    parameter int         IDX_W    = 4,
    parameter logic [7:0] RST_BASE = 8'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] regs [NUM_REGS];

    generate
        for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            // Purpose: hold one register, load on an addressed write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[gi] <= RST_BASE | 8'(gi);
                end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                    regs[gi] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/i2c_proto_engine.sv
// Module: i2c_proto_engine
// Target-side protocol sequencer: frames bytes, matches the device
// header, loads the register pointer, issues write strobes, streams read
// data, and tracks the master-code / high-speed flag.
// Assumes: edge and condition strobes come from i2c_line_sync, and SDA
// output changes are made only on an SCL falling edge.
module i2c_proto_engine
    import i2c_hs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52,
    parameter int         IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_pull,
    output logic             hs_mode
);

    tgt_state_e       state;
    ack_next_e        nxt;
    logic [2:0]       bit_cnt;
    logic [6:0]       shreg;
    logic [6:0]       txreg;
    logic [IDX_W-1:0] ptr;
    logic             in_txn;
    logic             fresh;
    logic             mc_seen;
    logic             hs_q;
    logic             pull_q;
    logic [7:0]       rx_byte;
    logic             byte_done;
    logic             rx_phase;

    // Purpose: assemble the byte including the bit arriving this edge
    always_comb begin
        rx_byte   = {shreg, sda_s};
        rx_phase  = (state == ST_DEV) || (state == ST_REG) || (state == ST_WDATA);
        byte_done = rx_phase && scl_rise && (bit_cnt == 3'd7);
    end

    // Purpose: write strobe on the last data bit, suppressed by bus conditions
    always_comb begin
        wr_en   = byte_done && (state == ST_WDATA) && !start_det && !stop_det;
        wr_idx  = ptr;
        wr_data = rx_byte;
    end

    // Purpose: main protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nxt     <= NX_DONE;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            in_txn  <= 1'b0;
            fresh   <= 1'b0;
            mc_seen <= 1'b0;
            hs_q    <= 1'b0;
            pull_q  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            pull_q  <= 1'b0;
            in_txn  <= 1'b1;
            fresh   <= ~in_txn;
            if (mc_seen) begin
                hs_q    <= 1'b1;
                mc_seen <= 1'b0;
            end
        end else if (stop_det) begin
            state   <= ST_IDLE;
            pull_q  <= 1'b0;
            in_txn  <= 1'b0;
            fresh   <= 1'b0;
            mc_seen <= 1'b0;
            hs_q    <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_REG, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= rx_byte[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            if (state == ST_DEV) begin
                                if (fresh && !hs_q && (rx_byte[7:3] == MCODE_PREFIX)) begin
                                    mc_seen <= 1'b1;
                                    state   <= ST_IDLE;
                                end else if (rx_byte[7:1] == DEV_ADDR) begin
                                    state <= ST_ACK_WAIT;
                                    nxt   <= rx_byte[0] ? NX_RDATA : NX_REG;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_REG) begin
                                ptr   <= rx_byte[IDX_W-1:0];
                                state <= ST_ACK_WAIT;
                                nxt   <= NX_WDATA;
                            end else begin
                                state <= ST_ACK_WAIT;
                                nxt   <= NX_DONE;
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) begin
                        pull_q <= 1'b1;
                        state  <= ST_ACK_HOLD;
                    end
                end
                ST_ACK_HOLD: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        case (nxt)
                            NX_REG: begin
                                pull_q <= 1'b0;
                                state  <= ST_REG;
                            end
                            NX_WDATA: begin
                                pull_q <= 1'b0;
                                state  <= ST_WDATA;
                            end
                            NX_RDATA: begin
                                txreg  <= rd_data[6:0];
                                pull_q <= ~rd_data[7];
                                state  <= ST_RDATA;
                            end
                            default: begin
                                pull_q <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_RLOAD: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        txreg   <= rd_data[6:0];
                        pull_q  <= ~rd_data[7];
                        state   <= ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            state <= ST_RACK_WAIT;
                        end
                    end else if (scl_fall) begin
                        pull_q <= ~txreg[6];
                        txreg  <= {txreg[5:0], 1'b0};
                    end
                end
                ST_RACK_WAIT: begin
                    if (scl_fall) begin
                        pull_q <= 1'b0;
                        state  <= ST_RACK;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            ptr   <= ptr + IDX_W'(1);
                            state <= ST_RLOAD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign rd_idx   = ptr;
    assign sda_pull = pull_q;
    assign hs_mode  = hs_q;

endmodule

// File: rtl/i2c_hs_target.sv
// Module: i2c_hs_target (top)
// I2C register target: synchronizer, protocol engine and register bank.
// Assumes: SDA pad is open-drain and driven low when sda_pull_o is 1;
// system clock >= 8x SCL; NUM_REGS is a power of two of at least 2.
module i2c_hs_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h52,
    parameter int         NUM_REGS    = 16,
    parameter logic [7:0] RST_BASE    = 8'hC0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    output logic hs_mode_o
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;

    i2c_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_proto_engine #(
        .DEV_ADDR (DEV_ADDR),
        .IDX_W    (IDX_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_pull  (sda_pull_o),
        .hs_mode   (hs_mode_o)
    );

    i2c_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .RST_BASE (RST_BASE)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/i2c_hs_target_chk.sv
// Module: i2c_hs_target_chk
// Property checker for i2c_hs_target, attached by bind below.
// Assumes: the master changes SDA only while SCL is low, except for
// deliberate START and STOP conditions.
module i2c_hs_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_pull,
    input logic hs_mode,
    input logic wr_en
);

    // R3: the pull-down only turns on in a cycle where SCL was low
    a_r3_pull_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !$past(scl_s));

    // R3: a STOP leaves SDA released
    a_r3_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // R11: the mode flag only rises at a START
    a_r11_hs_set_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> $past(start_det));

    // R11: the mode flag holds until a STOP
    a_r11_hs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_mode && !stop_det) |=> hs_mode);

    // R11: a STOP clears the mode flag
    a_r11_hs_cleared_by_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

    // R4: a register write never coincides with the target driving SDA
    a_r4_write_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sda_pull);

endmodule

bind i2c_hs_target i2c_hs_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull_o),
    .hs_mode   (hs_mode_o),
    .wr_en     (wr_en)
);

// File: tb/i2c_hs_target_test.sv
// Bench: bit-banged I2C master with a read-data scoreboard.
module i2c_hs_target_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_o;
    logic hs_mode_o;
    wire  sda_line = sda_m & ~sda_pull_o;

    int q = 5;          // system clocks per quarter bit
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_q [$];
    logic [7:0] mdl [16];

    always #5 clk = ~clk;

    i2c_hs_target uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull_o),
        .hs_mode_o  (hs_mode_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        b = sda_line; qw();
        scl_m = 1'b0; qw();
    endtask

    // Send a byte MSB first and return the acknowledge bit seen on the bus
    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(ack);
    endtask

    // Driver side: push expected byte, read it, hand result to the monitor
    task automatic m_rbyte(input logic [7:0] exp, input string tag, input logic mack);
        logic [7:0] d;
        logic b;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_wbit(mack);
        got_q.push_back(d);
    endtask

    task automatic wr_reg(input logic [7:0] ra, input logic [7:0] d, input string tag);
        logic a;
        m_start();
        m_wbyte(8'hA4, a); check({tag, " hdr ack"}, a, 0);
        m_wbyte(ra, a);    check({tag, " reg ack"}, a, 0);
        m_wbyte(d, a);     check({tag, " data ack"}, a, 0);
        m_stop();
    endtask

    task automatic set_ptr_rs();
        // caller has sent START; header + pointer already supplied by caller
    endtask

    task automatic rd_reg(input logic [7:0] ra, input logic [7:0] exp, input string tag);
        logic a;
        m_start();
        m_wbyte(8'hA4, a); check({tag, " hdr ack"}, a, 0);
        m_wbyte(ra, a);    check({tag, " reg ack"}, a, 0);
        m_start();
        m_wbyte(8'hA5, a); check({tag, " rd hdr ack"}, a, 0);
        m_rbyte(exp, tag, 1'b1);
        m_stop();
    endtask

    // Monitor: compare each read byte against the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g;
                logic [7:0] e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " read data"}, g, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        for (int i = 0; i < 16; i++) mdl[i] = 8'hC0 | 8'(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12: reset state
        check("R12 pull after reset", sda_pull_o, 0);
        check("R12 hs after reset", hs_mode_o, 0);

        // R12/R6: read with no pointer write starts at register 0
        m_start();
        m_wbyte(8'hA5, a); check("R6 read hdr ack", a, 0);
        m_rbyte(mdl[0], "R12 pointer zero", 1'b1);
        m_stop();
        check("R3 released after stop", sda_pull_o, 0);

        // R4: single write, then R2/R6 readback
        wr_reg(8'h05, 8'h3C, "R4 write reg5"); mdl[5] = 8'h3C;
        wr_reg(8'h01, 8'h77, "R4 write reg1"); mdl[1] = 8'h77;
        rd_reg(8'h05, mdl[5], "R2 R6 readback reg5");

        // R5: reset value of an untouched register
        rd_reg(8'h03, mdl[3], "R5 reset value reg3");

        // R7: burst with wrap, then NACK keeps pointer
        m_start();
        m_wbyte(8'hA4, a); check("R7 hdr ack", a, 0);
        m_wbyte(8'h0E, a); check("R7 reg ack", a, 0);
        m_start();
        m_wbyte(8'hA5, a); check("R7 rd hdr ack", a, 0);
        m_rbyte(mdl[14], "R7 burst b0", 1'b0);
        m_rbyte(mdl[15], "R7 burst b1", 1'b0);
        m_rbyte(mdl[0],  "R7 burst wrap", 1'b1);
        m_stop();
        m_start();
        m_wbyte(8'hA5, a); check("R7 rd hdr ack2", a, 0);
        m_rbyte(mdl[0], "R7 pointer kept on NACK", 1'b1);
        m_stop();

        // R8: wrong device address
        m_start();
        m_wbyte(8'hCC, a); check("R8 wrong hdr nack", a, 1);
        m_wbyte(8'h05, a); check("R8 reg byte ignored", a, 1);
        m_wbyte(8'hFF, a); check("R8 data byte ignored", a, 1);
        m_stop();
        rd_reg(8'h05, mdl[5], "R8 reg5 unchanged");

        // R5: upper address bits ignored
        wr_reg(8'h27, 8'h9D, "R5 write 0x27"); mdl[7] = 8'h9D;
        rd_reg(8'h07, mdl[7], "R5 alias readback");

        // R9: extra data byte
        m_start();
        m_wbyte(8'hA4, a); check("R9 hdr ack", a, 0);
        m_wbyte(8'h08, a); check("R9 reg ack", a, 0);
        m_wbyte(8'h11, a); check("R9 data ack", a, 0);
        m_wbyte(8'h22, a); check("R9 extra byte nack", a, 1);
        m_stop();
        mdl[8] = 8'h11;
        rd_reg(8'h08, mdl[8], "R9 first byte stored");
        rd_reg(8'h09, mdl[9], "R9 extra not stored");

        // R10/R11: master code and high-speed mode
        m_start();
        m_wbyte(8'h0B, a); check("R10 master code nack", a, 1);
        check("R10 hs not yet set", hs_mode_o, 0);
        m_start();
        check("R11 hs set at restart", hs_mode_o, 1);
        q = 3;
        m_wbyte(8'hA4, a); check("R11 hs hdr ack", a, 0);
        m_wbyte(8'h02, a); check("R11 hs reg ack", a, 0);
        m_wbyte(8'hA5, a); check("R11 hs data ack", a, 0);
        mdl[2] = 8'hA5;
        m_start();
        check("R11 hs held over restart", hs_mode_o, 1);
        m_wbyte(8'hA4, a); check("R11 hs hdr ack2", a, 0);
        m_wbyte(8'h02, a); check("R11 hs reg ack2", a, 0);
        m_start();
        m_wbyte(8'hA5, a); check("R11 hs rd hdr ack", a, 0);
        m_rbyte(mdl[2], "R11 hs read", 1'b1);
        check("R11 hs still set", hs_mode_o, 1);
        m_stop();
        check("R11 hs cleared by stop", hs_mode_o, 0);
        q = 5;
        rd_reg(8'h02, mdl[2], "R11 normal after hs");
        check("R11 hs stays clear", hs_mode_o, 0);

        // R1: START in the middle of a byte restarts framing
        m_start();
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
        m_start();
        m_wbyte(8'hA5, a); check("R1 hdr ack after restart", a, 0);
        m_rbyte(mdl[2], "R1 read after mid-byte restart", 1'b1);
        m_stop();
        check("R3 released at end", sda_pull_o, 0);

        repeat (20) @(negedge clk);
        check("scoreboard drained", got_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule